// File: doc/BRIEF.md
# JTAG Configuration Write Sequencer

This block is a JTAG master that streams a full set of configuration rows into the volatile configuration memory of a target programmable device. It generates TCK from the system clock through a run-time divider. It drives TMS and TDI so that the target's TAP controller runs a fixed program: forced reset, configuration enable with a settle time, selection of the write instruction, one data-register scan per row, then configuration disable with its own settle time, bypass and a return to Test-Logic-Reset.

Row contents come from an external row buffer over a request/ready pair. The sequencer presents a row index, raises a request, and holds TCK low until the buffer answers. It then takes the 274-bit data field and the 7-bit row address in the same cycle. A single-cycle start pulse launches a run. A sticky done flag reports the end of a run.

Top module: `jcfg_write_seq`

## Requirements
- R1: Out of reset and whenever no run is active, `tck_o`, `tms_o`, `tdi_o`, `row_req_o` and `busy_o` are all low.
- R2: A start pulse while idle sets `busy_o` on the next clock. A start pulse during a run has no effect: the run still loads exactly four instructions and sends exactly the configured number of rows.
- R3: A run opens with at least five TCK cycles with TMS high, followed by one with TMS low, so the TAP reaches Test-Logic-Reset and then Run-Test/Idle from any prior state.
- R4: The run loads four 8-bit instructions, each shifted least-significant bit first. In order they are enable 0xE8, write 0xE6, disable 0xC0 and bypass 0xFF.
- R5: After the enable instruction is updated, the TAP spends exactly 800 TCK cycles in Run-Test/Idle with TMS low before the next scan.
- R6: Each row is one 281-bit DR scan. The 274 data bits go first, bit 0 first, then the 7 address bits, bit 0 first. TMS is high only on the last address bit.
- R7: The TAP passes through Run-Test/Idle before every row's DR scan.
- R8: Rows are requested with indices 0 to 97 in ascending order. `row_req_o` and `row_idx_o` hold until `row_rdy_i` is seen, and TCK stays low while a request is pending.
- R9: After the last row, disable is followed by exactly 100 TCK cycles in Run-Test/Idle with TMS low. Then bypass is loaded and the TAP is left in Test-Logic-Reset, with `busy_o` low and TCK low.
- R10: Each TCK high phase and each low phase lasts `div_i`+1 system clocks. TMS and TDI change only in the clock where TCK falls, never while TCK is high.
- R11: `done_o` rises when `busy_o` falls at the end of a run. It stays high until the next accepted start, is cleared on that start, and is never high together with `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, honoured only while idle |
| div_i | input | 8 | TCK half-period minus one, in system clocks |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run finished; cleared by the next start |
| row_req_o | output | 1 | Row fetch request |
| row_idx_o | output | 7 | Index of the requested row |
| row_rdy_i | input | 1 | Row buffer answers; data and address are valid |
| row_data_i | input | 274 | Row data field |
| row_addr_i | input | 7 | Row address field |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to target |

## Verification
The properties assume that `div_i` stays constant for the whole of a run. They also assume that `row_rdy_i` is raised only while a request is pending and only for a single cycle. The bench drives a new divider value only between runs. Its row buffer model answers each request after zero to two cycles of stall, keeps ready up for exactly one clock, and drops it before the request could be seen again.

// File: rtl/jcfg_pkg.sv
package jcfg_pkg;
  localparam int IR_W      = 8;
  localparam int RST_EDGES = 6;  // five TMS-high, one TMS-low
  localparam int IR_PRE    = 4;  // RTI -> SelDR -> SelIR -> CapIR -> ShIR
  localparam int DR_PRE    = 3;  // RTI -> SelDR -> CapDR -> ShDR
  localparam int SCAN_POST = 2;  // Exit1 -> Update -> RTI
  localparam int TLR_EDGES = 3;

  typedef enum logic [3:0] {
    OP_RST, OP_IR_EN, OP_WAIT_EN, OP_IR_WR, OP_ROW,
    OP_IR_DIS, OP_WAIT_DIS, OP_IR_BYP, OP_TLR
  } op_e;

  function automatic logic is_ir(op_e op);
    return op inside {OP_IR_EN, OP_IR_WR, OP_IR_DIS, OP_IR_BYP};
  endfunction

  function automatic logic [IR_W-1:0] ir_code(op_e op);
    case (op)
      OP_IR_EN:  return 8'hE8;
      OP_IR_WR:  return 8'hE6;
      OP_IR_DIS: return 8'hC0;
      OP_IR_BYP: return 8'hFF;
      default:   return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/jcfg_tck_div.sv
module jcfg_tck_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tck_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tck_q;
  logic             hit;

  assign hit = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      tck_q <= ~tck_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign tck_o  = tck_q;
  assign fall_o = en_i && hit && tck_q;
endmodule

// File: rtl/jcfg_op_decode.sv
module jcfg_op_decode
  import jcfg_pkg::*;
#(
  parameter int SH_W      = 281,
  parameter int EN_DWELL  = 800,
  parameter int DIS_DWELL = 100,
  parameter int CNT_W     = 10
) (
  input  op_e              op_i,
  input  logic [CNT_W-1:0] bcnt_i,
  output logic             last_o,
  output logic             tms_o,
  output logic             body_o
);
  localparam int IR_BODY_END = IR_PRE + IR_W;
  localparam int DR_BODY_END = DR_PRE + SH_W;

  int b;
  assign b = int'(bcnt_i);

  always_comb begin
    last_o = 1'b0;
    tms_o  = 1'b0;
    body_o = 1'b0;
    case (op_i)
      OP_RST: begin
        last_o = (b == RST_EDGES - 1);
        tms_o  = (b <  RST_EDGES - 1);
      end
      OP_IR_EN, OP_IR_WR, OP_IR_DIS, OP_IR_BYP: begin
        last_o = (b == IR_BODY_END + SCAN_POST - 1);
        tms_o  = (b < 2) || (b == IR_BODY_END - 1) || (b == IR_BODY_END);
        body_o = (b >= IR_PRE) && (b < IR_BODY_END);
      end
      OP_WAIT_EN:  last_o = (b == EN_DWELL - 1);
      OP_WAIT_DIS: last_o = (b == DIS_DWELL - 1);
      OP_ROW: begin
        last_o = (b == DR_BODY_END + SCAN_POST - 1);
        tms_o  = (b == 0) || (b == DR_BODY_END - 1) || (b == DR_BODY_END);
        body_o = (b >= DR_PRE) && (b < DR_BODY_END);
      end
      OP_TLR: begin
        last_o = (b == TLR_EDGES - 1);
        tms_o  = 1'b1;
      end
      default: last_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/jcfg_shifter.sv
module jcfg_shifter #(
  parameter int W = 281
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= val_i;
    else if (shift_i) sh_q <= {1'b0, sh_q[W-1:1]};
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/jcfg_write_seq.sv
module jcfg_write_seq
  import jcfg_pkg::*;
#(
  parameter int ROWS      = 98,
  parameter int DATA_W    = 274,
  parameter int ADDR_W    = 7,
  parameter int EN_DWELL  = 800,
  parameter int DIS_DWELL = 100,
  parameter int DIV_W     = 8,
  localparam int IDX_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              row_req_o,
  output logic [IDX_W-1:0]  row_idx_o,
  input  logic              row_rdy_i,
  input  logic [DATA_W-1:0] row_data_i,
  input  logic [ADDR_W-1:0] row_addr_i,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o
);
  localparam int SH_W      = DATA_W + ADDR_W;
  localparam int ROW_EDGES = DR_PRE + SH_W + SCAN_POST;
  localparam int MAX_A     = (ROW_EDGES > EN_DWELL) ? ROW_EDGES : EN_DWELL;
  localparam int MAX_CNT   = (MAX_A > DIS_DWELL) ? MAX_A : DIS_DWELL;
  localparam int CNT_W     = $clog2(MAX_CNT + 1);

  logic             busy_q, done_q, fetch_q;
  op_e              op_q, next_op;
  logic [CNT_W-1:0] bcnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_row;
  logic             fall, dec_last, dec_tms, dec_body, sh_bit;
  logic             op_end, load_ir, load_row;
  logic [SH_W-1:0]  load_val;

  jcfg_tck_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_q && !fetch_q),
    .div_i  (div_i),
    .tck_o  (tck_o),
    .fall_o (fall)
  );

  jcfg_op_decode #(
    .SH_W(SH_W), .EN_DWELL(EN_DWELL), .DIS_DWELL(DIS_DWELL), .CNT_W(CNT_W)
  ) u_dec (
    .op_i   (op_q),
    .bcnt_i (bcnt_q),
    .last_o (dec_last),
    .tms_o  (dec_tms),
    .body_o (dec_body)
  );

  assign last_row = (idx_q == IDX_W'(ROWS - 1));
  assign op_end   = fall && dec_last;

  always_comb begin
    case (op_q)
      OP_RST:      next_op = OP_IR_EN;
      OP_IR_EN:    next_op = OP_WAIT_EN;
      OP_WAIT_EN:  next_op = OP_IR_WR;
      OP_IR_WR:    next_op = OP_ROW;
      OP_ROW:      next_op = last_row ? OP_IR_DIS : OP_ROW;
      OP_IR_DIS:   next_op = OP_WAIT_DIS;
      OP_WAIT_DIS: next_op = OP_IR_BYP;
      default:     next_op = OP_TLR;
    endcase
  end

  // One shifter serves both instruction and row scans
  assign load_row = fetch_q && row_rdy_i;
  assign load_ir  = op_end && is_ir(next_op);
  assign load_val = fetch_q ? {row_addr_i, row_data_i} : SH_W'(ir_code(next_op));

  jcfg_shifter #(.W(SH_W)) u_sh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_row || load_ir),
    .val_i   (load_val),
    .shift_i (fall && dec_body),
    .bit_o   (sh_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fetch_q <= 1'b0;
      op_q    <= OP_RST;
      bcnt_q  <= '0;
      idx_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        done_q  <= 1'b0;
        fetch_q <= 1'b0;
        op_q    <= OP_RST;
        bcnt_q  <= '0;
        idx_q   <= '0;
      end
    end else if (fetch_q) begin
      if (row_rdy_i) fetch_q <= 1'b0;
    end else if (fall) begin
      if (!dec_last) begin
        bcnt_q <= bcnt_q + CNT_W'(1);
      end else begin
        bcnt_q <= '0;
        op_q   <= next_op;
        if (op_q == OP_TLR) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (op_q == OP_IR_WR) begin
          fetch_q <= 1'b1;
        end else if (op_q == OP_ROW && !last_row) begin
          idx_q   <= idx_q + IDX_W'(1);
          fetch_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign row_req_o = fetch_q;
  assign row_idx_o = idx_q;
  assign tms_o     = busy_q && dec_tms;
  assign tdi_o     = busy_q && dec_body && sh_bit;
endmodule

// File: rtl/jcfg_write_seq_chk.sv
module jcfg_write_seq_chk #(
  parameter int IDX_W = 7,
  parameter int ROWS  = 98
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic             row_req_o,
  input logic             row_rdy_i,
  input logic [IDX_W-1:0] row_idx_o,
  input logic             tck_o,
  input logic             tms_o,
  input logic             tdi_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tck_o && !tms_o && !tdi_o && !row_req_o));

  a_r10_pins_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_o |-> ($stable(tms_o) && $stable(tdi_o)));

  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_req_o && !row_rdy_i) |=> (row_req_o && $stable(row_idx_o)));

  a_r8_no_tck_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_req_o |-> !tck_o);

  a_r8_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_req_o |-> (row_idx_o <= IDX_W'(ROWS - 1)));

  a_r11_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_end_sets_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

bind jcfg_write_seq jcfg_write_seq_chk #(.IDX_W(IDX_W), .ROWS(ROWS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .row_req_o (row_req_o),
  .row_rdy_i (row_rdy_i),
  .row_idx_o (row_idx_o),
  .tck_o     (tck_o),
  .tms_o     (tms_o),
  .tdi_o     (tdi_o)
);

// File: tb/jcfg_write_seq_tb.sv
`timescale 1ns/1ps
module jcfg_tap_model #(parameter int SHW = 281) (
  input logic tck,
  input logic tms,
  input logic tdi
);
  localparam int S_TLR = 0, S_RTI = 1, S_SELDR = 2, S_CAPDR = 3, S_SHDR = 4,
                 S_EX1DR = 5, S_PDR = 6, S_EX2DR = 7, S_UPDR = 8, S_SELIR = 9,
                 S_CAPIR = 10, S_SHIR = 11, S_EX1IR = 12, S_PIR = 13,
                 S_EX2IR = 14, S_UPIR = 15;
  int st, ir_n, dr_n, ir_cnt, dr_cnt, lead_ones, first_zero_st;
  bit zero_seen, rti_flag;
  logic [7:0]     ir_sh;
  logic [SHW-1:0] dr_sh;
  logic [7:0]     ir_log [0:15];
  int             ir_len [0:15];
  int             idle_cnt [0:15];
  logic [SHW-1:0] dr_log [0:127];
  int             dr_len [0:127];
  bit             rti_gap [0:127];

  task clear();
    st = S_SELDR; ir_n = 0; dr_n = 0; ir_cnt = 0; dr_cnt = 0;
    lead_ones = 0; first_zero_st = -1; zero_seen = 0; rti_flag = 0;
    ir_sh = '0; dr_sh = '0;
    for (int k = 0; k < 16; k++) idle_cnt[k] = 0;
  endtask

  function automatic int nxt(int s, logic m);
    case (s)
      S_TLR:   return m ? S_TLR   : S_RTI;
      S_RTI:   return m ? S_SELDR : S_RTI;
      S_SELDR: return m ? S_SELIR : S_CAPDR;
      S_CAPDR: return m ? S_EX1DR : S_SHDR;
      S_SHDR:  return m ? S_EX1DR : S_SHDR;
      S_EX1DR: return m ? S_UPDR  : S_PDR;
      S_PDR:   return m ? S_EX2DR : S_PDR;
      S_EX2DR: return m ? S_UPDR  : S_SHDR;
      S_UPDR:  return m ? S_SELDR : S_RTI;
      S_SELIR: return m ? S_TLR   : S_CAPIR;
      S_CAPIR: return m ? S_EX1IR : S_SHIR;
      S_SHIR:  return m ? S_EX1IR : S_SHIR;
      S_EX1IR: return m ? S_UPIR  : S_PIR;
      S_PIR:   return m ? S_EX2IR : S_PIR;
      S_EX2IR: return m ? S_UPIR  : S_SHIR;
      default: return m ? S_SELDR : S_RTI;
    endcase
  endfunction

  initial clear();

  always @(posedge tck) begin
    int n;
    n = nxt(st, tms);
    if (!zero_seen) begin
      if (tms) lead_ones++;
      else begin zero_seen = 1; first_zero_st = n; end
    end
    if (st == S_RTI && !tms && ir_n > 0 && ir_n <= 16) idle_cnt[ir_n-1]++;
    if (st == S_CAPIR) ir_cnt = 0;
    if (st == S_CAPDR) dr_cnt = 0;
    if (st == S_SHIR) begin ir_sh = {tdi, ir_sh[7:1]}; ir_cnt++; end
    if (st == S_SHDR) begin dr_sh = {tdi, dr_sh[SHW-1:1]}; dr_cnt++; end
    if (n == S_RTI) rti_flag = 1;
    if (n == S_UPIR && ir_n < 16) begin
      ir_log[ir_n] = ir_sh; ir_len[ir_n] = ir_cnt; ir_n++;
    end
    if (n == S_UPDR && dr_n < 128) begin
      dr_log[dr_n] = dr_sh; dr_len[dr_n] = dr_cnt; rti_gap[dr_n] = rti_flag;
      rti_flag = 0; dr_n++;
    end
    st = n;
  end
endmodule

module jcfg_write_seq_tb;
  localparam int DW = 274, AW = 7, SHW = DW + AW;
  localparam int S_TLR = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;

  logic          a_start, a_busy, a_done, a_req, a_rdy, a_tck, a_tms, a_tdi;
  logic [7:0]    a_div;
  logic [6:0]    a_idx;
  logic [DW-1:0] a_data;
  logic [AW-1:0] a_addr;

  logic          b_start, b_busy, b_done, b_req, b_rdy, b_tck, b_tms, b_tdi;
  logic [7:0]    b_div;
  logic [1:0]    b_idx;
  logic [DW-1:0] b_data;
  logic [AW-1:0] b_addr;

  jcfg_write_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(a_start), .div_i(a_div),
    .busy_o(a_busy), .done_o(a_done), .row_req_o(a_req), .row_idx_o(a_idx),
    .row_rdy_i(a_rdy), .row_data_i(a_data), .row_addr_i(a_addr),
    .tck_o(a_tck), .tms_o(a_tms), .tdi_o(a_tdi)
  );

  jcfg_write_seq #(.ROWS(3), .EN_DWELL(5), .DIS_DWELL(3)) u_dut_small (
    .clk_i(clk), .rst_ni(rst_n), .start_i(b_start), .div_i(b_div),
    .busy_o(b_busy), .done_o(b_done), .row_req_o(b_req), .row_idx_o(b_idx),
    .row_rdy_i(b_rdy), .row_data_i(b_data), .row_addr_i(b_addr),
    .tck_o(b_tck), .tms_o(b_tms), .tdi_o(b_tdi)
  );

  jcfg_tap_model #(.SHW(SHW)) u_tap       (.tck(a_tck), .tms(a_tms), .tdi(a_tdi));
  jcfg_tap_model #(.SHW(SHW)) u_tap_small (.tck(b_tck), .tms(b_tms), .tdi(b_tdi));

  function automatic logic [DW-1:0] row_data(int idx);
    logic [DW-1:0] v;
    for (int b = 0; b < DW; b++) v[b] = (((idx * 7) + (b * 3) + (b >> 4)) % 5) < 2;
    return v;
  endfunction

  function automatic logic [AW-1:0] row_addr(int idx);
    return AW'((idx * 37 + 11) % 128);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Row buffer models: stall idx%3 cycles, one-cycle ready
  int a_served = 0, a_stall = 0, a_tck_fetch = 0;
  bit a_order_bad = 0;
  initial begin
    a_rdy = 0; a_data = '0; a_addr = '0;
    forever begin
      @(negedge clk);
      if (a_req && a_tck) a_tck_fetch++;
      if (a_req && !a_rdy) begin
        if (a_stall >= int'(a_idx) % 3) begin
          if (int'(a_idx) != a_served) a_order_bad = 1;
          a_data = row_data(int'(a_idx)); a_addr = row_addr(int'(a_idx));
          a_rdy = 1; a_served++; a_stall = 0;
        end else a_stall++;
      end else a_rdy = 0;
    end
  end

  int b_served = 0, b_stall = 0;
  bit b_order_bad = 0;
  initial begin
    b_rdy = 0; b_data = '0; b_addr = '0;
    forever begin
      @(negedge clk);
      if (b_req && !b_rdy) begin
        if (b_stall >= int'(b_idx) % 3) begin
          if (int'(b_idx) != b_served) b_order_bad = 1;
          b_data = row_data(int'(b_idx)); b_addr = row_addr(int'(b_idx));
          b_rdy = 1; b_served++; b_stall = 0;
        end else b_stall++;
      end else b_rdy = 0;
    end
  end

  task automatic check_stream(input int which, input int rows,
                              input int en_dwell, input int dis_dwell);
    int irn, drn, lead, fz, fin, bad_len, bad_val, bad_gap;
    logic [7:0] exp_ir [0:3];
    exp_ir[0] = 8'hE8; exp_ir[1] = 8'hE6; exp_ir[2] = 8'hC0; exp_ir[3] = 8'hFF;
    irn  = which == 0 ? u_tap.ir_n          : u_tap_small.ir_n;
    drn  = which == 0 ? u_tap.dr_n          : u_tap_small.dr_n;
    lead = which == 0 ? u_tap.lead_ones     : u_tap_small.lead_ones;
    fz   = which == 0 ? u_tap.first_zero_st : u_tap_small.first_zero_st;
    fin  = which == 0 ? u_tap.st            : u_tap_small.st;
    check(lead >= 5, "R3", "leading TMS-high cycles", lead, 5);
    check(fz == 1, "R3", "state after first TMS low (1=RTI)", fz, 1);
    check(irn == 4, "R4", "instruction loads", irn, 4);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] v; int l;
      v = which == 0 ? u_tap.ir_log[k] : u_tap_small.ir_log[k];
      l = which == 0 ? u_tap.ir_len[k] : u_tap_small.ir_len[k];
      check(v == exp_ir[k] && l == 8, "R4", $sformatf("instruction %0d", k), v, exp_ir[k]);
    end
    check((which == 0 ? u_tap.idle_cnt[0] : u_tap_small.idle_cnt[0]) == en_dwell,
          "R5", "idle after enable",
          which == 0 ? u_tap.idle_cnt[0] : u_tap_small.idle_cnt[0], en_dwell);
    check(drn == rows, "R8", "rows scanned", drn, rows);
    bad_len = 0; bad_val = 0; bad_gap = 0;
    for (int k = 0; k < rows && k < 128; k++) begin
      logic [SHW-1:0] v; int l; bit g;
      v = which == 0 ? u_tap.dr_log[k]  : u_tap_small.dr_log[k];
      l = which == 0 ? u_tap.dr_len[k]  : u_tap_small.dr_len[k];
      g = which == 0 ? u_tap.rti_gap[k] : u_tap_small.rti_gap[k];
      if (l != SHW) bad_len++;
      if (v !== {row_addr(k), row_data(k)}) bad_val++;
      if (!g) bad_gap++;
    end
    check(bad_len == 0, "R6", "rows with wrong scan length", bad_len, 0);
    check(bad_val == 0, "R6", "rows with wrong content", bad_val, 0);
    check(bad_gap == 0, "R7", "rows without preceding idle", bad_gap, 0);
    check((which == 0 ? u_tap.idle_cnt[2] : u_tap_small.idle_cnt[2]) == dis_dwell,
          "R9", "idle after disable",
          which == 0 ? u_tap.idle_cnt[2] : u_tap_small.idle_cnt[2], dis_dwell);
    check(fin == S_TLR, "R9", "final TAP state (0=TLR)", fin, S_TLR);
  endtask

  task automatic wait_idle(input int which, input int limit);
    int n = 0;
    while ((which == 0 ? a_busy : b_busy) && n < limit) begin
      @(negedge clk); n++;
    end
    check(n < limit, "R9", "run completes in time", n, limit);
  endtask

  task automatic t_reset();
    check(!a_tck && !a_tms && !a_tdi && !a_req && !a_busy && !a_done,
          "R1", "outputs in reset", {a_tck, a_tms, a_tdi, a_req, a_busy, a_done}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!a_tck && !a_tms && !a_tdi && !a_req && !a_busy && !a_done,
          "R1", "outputs idle after reset", {a_tck, a_tms, a_tdi, a_req, a_busy, a_done}, 0);
  endtask

  task automatic t_full_run();
    u_tap.clear(); a_served = 0; a_order_bad = 0; a_tck_fetch = 0;
    a_div = 8'd0;
    a_start = 1'b1; @(negedge clk); a_start = 1'b0;
    check(a_busy == 1'b1, "R2", "busy after start", a_busy, 1);
    repeat (60) @(negedge clk);
    a_start = 1'b1; @(negedge clk); a_start = 1'b0;  // must be ignored
    wait_idle(0, 150000);
    check_stream(0, 98, 800, 100);
    check(a_served == 98 && !a_order_bad, "R8", "rows served in order", a_served, 98);
    check(a_tck_fetch == 0, "R8", "TCK high during fetch", a_tck_fetch, 0);
    check(a_done && !a_busy && !a_tck, "R9", "end state done/busy/tck",
          {a_done, a_busy, a_tck}, 3'b100);
    check(u_tap.ir_n == 4, "R2", "late start did not restart", u_tap.ir_n, 4);
    repeat (20) @(negedge clk);
    check(a_done == 1'b1, "R11", "done holds while idle", a_done, 1);
  endtask

  task automatic t_clock_phases();
    int hi = 0, lo = 0, n = 0;
    u_tap_small.clear(); b_served = 0; b_order_bad = 0;
    b_div = 8'd2;
    b_start = 1'b1; @(negedge clk); b_start = 1'b0;
    while (!b_tck && n < 50) begin @(negedge clk); n++; end
    while (b_tck && hi < 50) begin @(negedge clk); hi++; end
    while (!b_tck && lo < 50) begin @(negedge clk); lo++; end
    check(hi == 3, "R10", "TCK high clocks at div 2", hi, 3);
    check(lo == 3, "R10", "TCK low clocks at div 2", lo, 3);
    wait_idle(1, 20000);
    check_stream(1, 3, 5, 3);
    check(b_served == 3 && !b_order_bad, "R8", "small rows served in order", b_served, 3);
  endtask

  task automatic t_restart();
    u_tap_small.clear(); b_served = 0; b_order_bad = 0;
    b_div = 8'd0;
    check(b_done == 1'b1, "R11", "done before restart", b_done, 1);
    b_start = 1'b1; @(negedge clk); b_start = 1'b0;
    check(!b_done && b_busy, "R11", "done cleared on start", {b_done, b_busy}, 2'b01);
    wait_idle(1, 20000);
    check(b_done == 1'b1, "R11", "done set after second run", b_done, 1);
    check_stream(1, 3, 5, 3);
  endtask

  initial begin
    a_start = 0; b_start = 0; a_div = 0; b_div = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_full_run();
    t_clock_phases();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #950000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule